// File: doc/BRIEF.md
# Condition Test Predicate Evaluator

This block decides whether a predicated micro-operation may run. It takes a status flag word and a 5-bit condition code, and it returns a single predicate bit in the same cycle. The logic is purely combinational and holds no state.

The low four bits of the code select one of sixteen base tests:

- constant true;
- single-flag tests on the carry, zero, sign, overflow and parity flags;
- single-flag tests on the two emulation flags (emulation carry and emulation zero);
- a gated-zero test that combines the emulation zero flag with the real zero flag;
- the unsigned below-or-equal test;
- the signed less and less-or-equal tests.

When bit 4 of the code is set, the base test is inverted. Four base tests are reserved for string operations and have no defined meaning. A code that selects one of them, with either polarity, raises an unsupported output and forces the predicate to 1.

The position of each flag inside the flag word is a parameter. The block can therefore sit behind any flag register layout.

Top module: `cond_eval`

## Requirements
- R1: Code 0 gives pred_o = 1 and code 16 gives pred_o = 0, for every flag word.
- R2: The single-flag tests follow the named flag directly. Code 1 follows the emulation carry flag, code 2 the emulation zero flag, code 8 overflow, code 9 carry, code 10 zero, code 12 sign and code 13 parity.
- R3: Code 3 gives pred_o = NOT((NOT ezf) AND zf). It is 0 only when the zero flag is set and the emulation zero flag is clear.
- R4: Code 11 gives pred_o = cf OR zf.
- R5: Code 14 gives pred_o = sf XOR of. Code 15 gives pred_o = (sf XOR of) OR zf.
- R6: For any code c in 16..31 whose low nibble is not 4..7, pred_o is the inverse of what code c-16 gives for the same flags.
- R7: Codes 4..7 and 20..23 drive unsup_o = 1 and pred_o = 1, whatever the flags.
- R8: Every other code drives unsup_o = 0.
- R9: Bits of flags_i that are not at one of the seven parameterised flag positions have no effect on either output.
- R10: The flag positions are set by the parameters CF_POS, PF_POS, ECF_POS, EZF_POS, ZF_POS, SF_POS and OF_POS. The defaults are 0, 2, 3, 5, 6, 7 and 11, in a 16-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flags_i | input | FLAG_W | Status flag word |
| cond_i | input | 5 | Condition code: bit 4 inverts, bits 3:0 select the base test |
| pred_o | output | 1 | 1 when the micro-operation may execute |
| unsup_o | output | 1 | 1 when the code is one of the reserved string conditions |

## Verification
The bench builds two copies of the block. The first uses the default 16-bit layout. The second uses an 8-bit word with all seven flag positions reversed and packed into bits 7 down to 1. Comparing the two shows that every flag is taken from its parameterised position and not from a fixed bit. It also shows that the free bits (the nine spare bits of the default word and bit 0 of the narrow one) are ignored. Random flag words are swept across all 32 codes. Directed cases add the two flag combinations that separate the gated-zero test from a plain zero test.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
  localparam int unsigned CODE_W = 5;

  // Base tests in code order; bit 4 of the code inverts the result.
  typedef enum logic [3:0] {
    T_ALWAYS   = 4'd0,
    T_ECF      = 4'd1,
    T_EZF      = 4'd2,
    T_GATED_Z  = 4'd3,
    T_STR_A    = 4'd4,
    T_STR_B    = 4'd5,
    T_STR_C    = 4'd6,
    T_STR_D    = 4'd7,
    T_OF       = 4'd8,
    T_CF       = 4'd9,
    T_ZF       = 4'd10,
    T_BE       = 4'd11,
    T_SF       = 4'd12,
    T_PF       = 4'd13,
    T_LT       = 4'd14,
    T_LE       = 4'd15
  } base_test_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic ecf;
    logic ezf;
    logic zf;
    logic sf;
    logic of;
  } cc_flags_t;
endpackage

// File: rtl/cond_flag_pick.sv
module cond_flag_pick
  import cond_eval_pkg::*;
#(
  parameter int unsigned FLAG_W  = 16,
  parameter int unsigned CF_POS  = 0,
  parameter int unsigned PF_POS  = 2,
  parameter int unsigned ECF_POS = 3,
  parameter int unsigned EZF_POS = 5,
  parameter int unsigned ZF_POS  = 6,
  parameter int unsigned SF_POS  = 7,
  parameter int unsigned OF_POS  = 11
) (
  input  logic [FLAG_W-1:0] flags_i,
  output cc_flags_t         cc_o
);
  always_comb begin
    cc_o.cf  = flags_i[CF_POS];
    cc_o.pf  = flags_i[PF_POS];
    cc_o.ecf = flags_i[ECF_POS];
    cc_o.ezf = flags_i[EZF_POS];
    cc_o.zf  = flags_i[ZF_POS];
    cc_o.sf  = flags_i[SF_POS];
    cc_o.of  = flags_i[OF_POS];
  end
endmodule

// File: rtl/cond_base_eval.sv
module cond_base_eval
  import cond_eval_pkg::*;
(
  input  base_test_e sel_i,
  input  cc_flags_t  cc_i,
  output logic       hit_o,
  output logic       str_o
);
  always_comb begin
    hit_o = 1'b1;
    str_o = 1'b0;
    case (sel_i)
      T_ALWAYS:  hit_o = 1'b1;
      T_ECF:     hit_o = cc_i.ecf;
      T_EZF:     hit_o = cc_i.ezf;
      T_GATED_Z: hit_o = ~(~cc_i.ezf & cc_i.zf);
      T_STR_A,
      T_STR_B,
      T_STR_C,
      T_STR_D:   str_o = 1'b1;
      T_OF:      hit_o = cc_i.of;
      T_CF:      hit_o = cc_i.cf;
      T_ZF:      hit_o = cc_i.zf;
      T_BE:      hit_o = cc_i.cf | cc_i.zf;
      T_SF:      hit_o = cc_i.sf;
      T_PF:      hit_o = cc_i.pf;
      T_LT:      hit_o = cc_i.sf ^ cc_i.of;
      T_LE:      hit_o = (cc_i.sf ^ cc_i.of) | cc_i.zf;
      default:   hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_eval_pkg::*;
#(
  parameter int unsigned FLAG_W  = 16,
  parameter int unsigned CF_POS  = 0,
  parameter int unsigned PF_POS  = 2,
  parameter int unsigned ECF_POS = 3,
  parameter int unsigned EZF_POS = 5,
  parameter int unsigned ZF_POS  = 6,
  parameter int unsigned SF_POS  = 7,
  parameter int unsigned OF_POS  = 11
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [CODE_W-1:0] cond_i,
  output logic              pred_o,
  output logic              unsup_o
);
  localparam int unsigned INV_BIT = CODE_W - 1;

  cc_flags_t  cc;
  base_test_e sel;
  logic       hit;
  logic       str;

  assign sel = base_test_e'(cond_i[INV_BIT-1:0]);

  cond_flag_pick #(
    .FLAG_W (FLAG_W),
    .CF_POS (CF_POS),
    .PF_POS (PF_POS),
    .ECF_POS(ECF_POS),
    .EZF_POS(EZF_POS),
    .ZF_POS (ZF_POS),
    .SF_POS (SF_POS),
    .OF_POS (OF_POS)
  ) u_pick (
    .flags_i(flags_i),
    .cc_o   (cc)
  );

  cond_base_eval u_base (
    .sel_i(sel),
    .cc_i (cc),
    .hit_o(hit),
    .str_o(str)
  );

  // Reserved string tests: flag them and let the op run.
  assign unsup_o = str;
  assign pred_o  = str | (hit ^ cond_i[INV_BIT]);
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
  parameter int unsigned FLAG_W  = 16,
  parameter int unsigned CF_POS  = 0,
  parameter int unsigned ZF_POS  = 6,
  parameter int unsigned EZF_POS = 5
) (
  input logic [FLAG_W-1:0] flags_i,
  input logic [4:0]        cond_i,
  input logic              pred_o,
  input logic              unsup_o
);
  always_comb begin
    if (cond_i == 5'd0)  AST_ALWAYS_TRUE: assert (pred_o);             // R1
    if (cond_i == 5'd16) AST_ALWAYS_FALSE: assert (!pred_o);           // R1
    if (cond_i == 5'd3)
      AST_GATED_ZERO: assert (pred_o == !(!flags_i[EZF_POS] && flags_i[ZF_POS])); // R3
    if (cond_i == 5'd11)
      AST_BELOW_EQ: assert (pred_o == (flags_i[CF_POS] || flags_i[ZF_POS])); // R4
    if (unsup_o) AST_UNSUP_RUNS: assert (pred_o);                      // R7
    if (cond_i[3:2] != 2'b01) AST_UNSUP_ONLY_STR: assert (!unsup_o);   // R8
  end
endmodule

bind cond_eval cond_eval_chk #(
  .FLAG_W (FLAG_W),
  .CF_POS (CF_POS),
  .ZF_POS (ZF_POS),
  .EZF_POS(EZF_POS)
) u_chk (
  .flags_i(flags_i),
  .cond_i (cond_i),
  .pred_o (pred_o),
  .unsup_o(unsup_o)
);

// File: tb/sim_cond_eval.sv
module sim_cond_eval;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] fw0;
  logic [7:0]  fw1;
  logic [4:0]  code;
  logic        p0, u0_un, p1, u1_un;

  cond_eval u0 (.flags_i(fw0), .cond_i(code), .pred_o(p0), .unsup_o(u0_un));

  cond_eval #(
    .FLAG_W(8), .CF_POS(7), .PF_POS(6), .ECF_POS(5), .EZF_POS(4),
    .ZF_POS(3), .SF_POS(2), .OF_POS(1)
  ) u1 (.flags_i(fw1), .cond_i(code), .pred_o(p1), .unsup_o(u1_un));

  // logical flags: {cf,pf,ecf,ezf,zf,sf,of}
  function automatic logic [15:0] pack0(logic [6:0] f, logic [15:0] junk);
    logic [15:0] w;
    w = junk & ~16'h08ED;
    w[0] = f[6]; w[2] = f[5]; w[3] = f[4]; w[5] = f[3];
    w[6] = f[2]; w[7] = f[1]; w[11] = f[0];
    return w;
  endfunction

  function automatic logic [7:0] pack1(logic [6:0] f, logic junk);
    return {f, junk};
  endfunction

  function automatic logic base_ref(logic [3:0] t, logic [6:0] f);
    logic cf, pf, ecf, ezf, zf, sf, of;
    {cf, pf, ecf, ezf, zf, sf, of} = f;
    case (t)
      4'd0:  return 1'b1;
      4'd1:  return ecf;
      4'd2:  return ezf;
      4'd3:  return !(zf && !ezf);
      4'd8:  return of;
      4'd9:  return cf;
      4'd10: return zf;
      4'd11: return cf || zf;
      4'd12: return sf;
      4'd13: return pf;
      4'd14: return sf != of;
      4'd15: return (sf != of) || zf;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(logic [4:0] c);
    logic [3:0] t;
    t = c[3:0];
    if (t >= 4 && t <= 7) return "R7";
    if (c[4] && t != 0) return "R6";
    case (t)
      4'd0: return "R1";
      4'd3: return "R3";
      4'd11: return "R4";
      4'd14, 4'd15: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s code=%0d actual=%b expected=%b", req, what, code, act, exp);
    end
  endtask

  task automatic apply(logic [4:0] c, logic [6:0] f, logic [15:0] junk);
    logic str, ep, eu;
    @(posedge clk);
    code = c;
    fw0 = pack0(f, junk);
    fw1 = pack1(f, junk[0]);
    #1;
    str = (c[3:0] >= 4 && c[3:0] <= 7);
    eu  = str;
    ep  = str ? 1'b1 : (base_ref(c[3:0], f) ^ c[4]);
    check(req_of(c), "u0 pred", p0, ep);
    check(str ? "R7" : "R8", "u0 unsup", u0_un, eu);
    check("R10", "u1 pred", p1, ep);
    check(str ? "R7" : "R8", "u1 unsup", u1_un, eu);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] f;
    logic [15:0] j;
    logic [4:0] c;
    void'($urandom(32'h1F3A5));
    code = '0; fw0 = '0; fw1 = '0;
    repeat (2) @(posedge clk);
    // R1: constant tests under all-ones and all-zero flags
    apply(5'd0, 7'h00, 16'h0000);
    apply(5'd0, 7'h7F, 16'hFFFF);
    apply(5'd16, 7'h7F, 16'hFFFF);
    apply(5'd16, 7'h00, 16'h0000);
    // R3: the two cases separating gated zero from plain zero
    apply(5'd3, 7'b0000100, 16'h0);   // zf=1 ezf=0 -> 0
    apply(5'd3, 7'b0001100, 16'h0);   // zf=1 ezf=1 -> 1
    apply(5'd19, 7'b0000100, 16'h0);
    // R7: reserved codes both polarities
    for (int k = 4; k < 8; k++) begin
      apply(5'(k), 7'h00, 16'h0);
      apply(5'(k + 16), 7'h7F, 16'hFFFF);
    end
    // R9: spare bits toggled must not change results
    for (int k = 0; k < 32; k++) begin
      apply(5'(k), 7'h2A, 16'h0000);
      apply(5'(k), 7'h2A, 16'hFFFF);
    end
    // R2 R4 R5 R6: random sweep over all codes
    for (int n = 0; n < 3000; n++) begin
      f = 7'($urandom);
      j = 16'($urandom);
      c = 5'($urandom);
      apply(c, f, j);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule